// File: doc/BRIEF.md
# Late-write pipelined burst SRAM

This block is a synthesizable model of one synchronous SRAM array built so that reads and writes can be issued on every clock with no idle cycle when the direction changes. Every command input is captured on the rising clock edge. A read returns its word two enabled edges after the command. A write takes its data two enabled edges after the command. Because both directions share the same two-edge latency, any mix of reads and writes keeps the data path fully used.

A command starts a four-beat burst. The following cycles can advance the burst without a new address: the low two address bits step in linear or interleaved order and wrap back to the start after four beats. A clock-enable input freezes the whole block. An asynchronous output enable gates the read data. A separate valid flag marks the read data as driven, so that no tri-state pad is needed inside the block.

Top module: `lwburst_sram`

## Requirements
- R1: A read command is one enabled edge (cken_n=0) with adv=0, sel=1 and wr_n=1. For a read command at enabled edge C, rdata holds the addressed word and rvalid=1 (with oe_n=0) after enabled edge C+2. Read commands may be issued on every cycle.
- R2: A write command is an enabled edge with adv=0, sel=1 and wr_n=0. Its data is taken from wdata at the second enabled edge after the command. Byte lane i (wdata[8i+7:8i]) is stored only when be_n[i]=0 at the command edge.
- R3: A write command with be_n=4'b1111 leaves the array unchanged.
- R4: Writes and reads may alternate on consecutive cycles with no idle cycle. A read issued on the cycle after a write to the same address returns the newly written data.
- R5: An enabled edge with adv=1 after a burst start continues the burst, and the addr input is ignored. Beat k (k=1,2,3) keeps the upper address bits of the start address S. With lin_order=1 the low two bits are (S[1:0]+k) mod 4; with lin_order=0 they are S[1:0] xor k. The fifth beat wraps to S.
- R6: A continued burst keeps the operation type of the command that started it, whatever wr_n is during the continuation.
- R7: While cken_n=1, all inputs other than oe_n are ignored and every register, including the pipeline stages and rdata/rvalid, holds its value.
- R8: An enabled edge with adv=0 and sel=0 is a deselect and produces no access. Continuation cycles (adv=1) after a deselect produce no access either.
- R9: While oe_n=1, rvalid is 0 without waiting for a clock. A read issued with oe_n=1 still advances through the pipeline (dummy read), and its data appears when oe_n goes low.
- R10: A synchronous active-low reset clears the pipeline and burst state, so rvalid=0 after reset. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the pipeline state |
| cken_n | input | 1 | Clock enable, active low; high freezes the block |
| sel | input | 1 | Chip select, active high |
| adv | input | 1 | 0: load a new command; 1: continue the current burst |
| wr_n | input | 1 | 0: write command, 1: read command |
| be_n | input | DW/8 | Active-low byte-lane write strobes |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved (held static) |
| addr | input | $clog2(DEPTH) | Word address, used when adv=0 |
| wdata | input | DW | Write data, sampled two enabled edges after its command |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DW | Read data from the output register |
| rvalid | output | 1 | rdata carries valid read data and is driven |

## Verification
A wrong address in the burst counter or the pipeline shows up as a rdata mismatch two enabled edges after the beat that used it. A corrupted write is seen only when that address is read back later, so every write region is read again in full. A lost or extra valid bit appears at once as a wrong rvalid on the cycle the data would arrive. A stage that does not hold during a stall shows as rdata or rvalid changing on a frozen cycle.

// File: rtl/lwburst_sram.sv
module lwburst_sram #(
  parameter int DEPTH = 64,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cken_n,
  input  logic                     sel,
  input  logic                     adv,
  input  logic                     wr_n,
  input  logic [DW/8-1:0]          be_n,
  input  logic                     lin_order,
  input  logic [$clog2(DEPTH)-1:0] addr,
  input  logic [DW-1:0]            wdata,
  input  logic                     oe_n,
  output logic [DW-1:0]            rdata,
  output logic                     rvalid
);
  localparam int AW    = $clog2(DEPTH);
  localparam int LANES = DW / 8;

  logic [DW-1:0] mem [DEPTH];

  logic          burst_on, burst_wr;
  logic [AW-1:0] base;
  logic [1:0]    cnt;

  logic             s1_vld, s1_wr, s2_vld, s2_wr;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;
  logic [DW-1:0]    dq;
  logic             dvalid;

  wire [1:0]    cnt_nx   = cnt + 2'd1;
  wire [1:0]    low_nx   = lin_order ? (base[1:0] + cnt_nx) : (base[1:0] ^ cnt_nx);
  wire [AW-1:0] cur_addr = adv ? {base[AW-1:2], low_nx} : addr;
  wire          cur_go   = adv ? burst_on : sel;
  wire          cur_wr   = adv ? burst_wr : !wr_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_on <= 1'b0;
      s1_vld   <= 1'b0;
      s2_vld   <= 1'b0;
      dvalid   <= 1'b0;
    end else if (!cken_n) begin
      if (!adv) begin
        burst_on <= sel;
        burst_wr <= !wr_n;
        base     <= addr;
        cnt      <= 2'd0;
      end else if (burst_on) begin
        cnt <= cnt_nx;
      end
      s1_vld  <= cur_go;
      s1_wr   <= cur_wr;
      s1_addr <= cur_addr;
      s1_be   <= be_n;
      s2_vld  <= s1_vld;
      s2_wr   <= s1_wr;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      dvalid  <= s2_vld && !s2_wr;
      if (s2_vld && !s2_wr) dq <= mem[s2_addr];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !cken_n && s2_vld && s2_wr)
      for (int i = 0; i < LANES; i++)
        if (!s2_be[i]) mem[s2_addr][i*8 +: 8] <= wdata[i*8 +: 8];
  end

  assign rdata  = dq;
  assign rvalid = dvalid && !oe_n;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rst_n |=> (!s1_vld && !s2_vld && !dvalid)); // R10

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && cken_n) |=> ($stable(dq) && $stable(dvalid) && $stable(s1_vld) && $stable(s2_vld))); // R7

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && !adv && !sel) |=> !s1_vld); // R8

  AST_BURST_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    (!cken_n && adv && burst_on) |=> (s1_vld && (s1_wr == $past(burst_wr)))); // R6

  AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rvalid); // R9
endmodule

// File: tb/lwburst_sram_test.sv
`timescale 1ns/100ps
module lwburst_sram_test;
  logic        clk = 1'b0;
  logic        rst_n, cken_n, sel, adv, wr_n, lin_order, oe_n;
  logic [3:0]  be_n;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        rvalid;

  int vectors = 0;
  int fails   = 0;

  lwburst_sram #(.DEPTH(64), .DW(32)) uut (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sel(sel), .adv(adv),
    .wr_n(wr_n), .be_n(be_n), .lin_order(lin_order), .addr(addr),
    .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
  );

  always #2.5 clk = ~clk;

  logic [31:0] refm [64];
  bit          q1v, q1w, q2v, q2w, ev, bact, bwr;
  logic [5:0]  q1a, q2a, bbase;
  logic [3:0]  q1b, q2b;
  logic [31:0] q1d, q2d, ed;
  logic [1:0]  bk;

  function automatic logic [31:0] fv(int k);
    return 32'h9E3779B9 * (k + 1);
  endfunction

  task automatic step(input bit ck, input bit s, input bit a, input bit w,
                      input logic [3:0] b, input logic [5:0] ad,
                      input logic [31:0] wd, input bit oe, input string tag);
    bit         nv, nw;
    logic [5:0] na;
    cken_n = ck; sel = s; adv = a; wr_n = w; be_n = b; addr = ad; oe_n = oe;
    wdata  = q2d;
    @(posedge clk);
    if (!ck) begin
      if (q2v && q2w)
        for (int i = 0; i < 4; i++)
          if (!q2b[i]) refm[q2a][i*8 +: 8] = q2d[i*8 +: 8];
      ev = q2v && !q2w;
      if (ev) ed = refm[q2a];
      nv = 1'b0; nw = 1'b0; na = ad;
      if (!a) begin
        if (s) begin bact = 1'b1; bbase = ad; bk = 2'd0; bwr = !w; nv = 1'b1; nw = !w; end
        else bact = 1'b0;
      end else if (bact) begin
        bk = bk + 2'd1;
        na = {bbase[5:2], lin_order ? (bbase[1:0] + bk) : (bbase[1:0] ^ bk)};
        nv = 1'b1; nw = bwr;
      end
      q2v = q1v; q2w = q1w; q2a = q1a; q2b = q1b; q2d = q1d;
      q1v = nv;  q1w = nw;  q1a = na;  q1b = b;   q1d = wd;
    end
    @(negedge clk);
    vectors++;
    if (rvalid !== (ev && !oe) || (ev && !oe && rdata !== ed)) begin
      fails++;
      $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               tag, rvalid, rdata, ev && !oe, ed);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 4'hF, 6'd0, 32'd0, 0, tag);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cken_n = 1'b0; sel = 1'b0; adv = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q1v = 0; q2v = 0; ev = 0; bact = 0;
    vectors++;
    if (rvalid !== 1'b0) begin
      fails++;
      $display("FAIL R10: rvalid=%0b expected rvalid=0", rvalid);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    lin_order = 1'b0; wr_n = 1'b1; be_n = 4'hF; addr = '0; wdata = '0;
    q1d = '0; q2d = '0; ed = '0;
    do_reset();

    // R2: fill the whole array with back-to-back writes
    for (int k = 0; k < 64; k++) step(0, 1, 0, 0, 4'h0, 6'(k), fv(k), 0, "R2");
    idle(2, "R8");
    // R1: back-to-back reads of every address
    for (int k = 0; k < 64; k++) step(0, 1, 0, 1, 4'hF, 6'(k), 32'd0, 0, "R1");
    idle(2, "R1");

    // R2/R3: every byte strobe pattern
    for (int p = 0; p < 16; p++)
      step(0, 1, 0, 0, 4'(p), 6'(p), ~fv(p + 7), 0, (p == 15) ? "R3" : "R2");
    idle(2, "R2");
    for (int p = 0; p < 16; p++)
      step(0, 1, 0, 1, 4'hF, 6'(p), 32'd0, 0, (p == 15) ? "R3" : "R2");
    idle(2, "R2");

    // R4: alternate write and read of the same address every cycle
    for (int k = 0; k < 16; k++) begin
      step(0, 1, 0, 0, 4'h0, 6'(40 + k), fv(100 + k), 0, "R4");
      step(0, 1, 0, 1, 4'hF, 6'(40 + k), 32'd0, 0, "R4");
    end
    idle(2, "R4");

    // R5: read bursts in both orders from every start offset, with wrap
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++) begin
        lin_order = m[0];
        step(0, 1, 0, 1, 4'hF, 6'(48 + s), 32'd0, 0, "R5");
        for (int k = 0; k < 4; k++) step(0, 0, 1, 1, 4'hF, 6'h3F, 32'd0, 0, "R5");
        idle(2, "R5");
      end

    // R6: write burst continued with wr_n=1, read burst continued with wr_n=0
    lin_order = 1'b1;
    step(0, 1, 0, 0, 4'h0, 6'd21, fv(200), 0, "R6");
    for (int k = 1; k < 4; k++) step(0, 1, 1, 1, 4'h0, 6'd0, fv(200 + k), 0, "R6");
    idle(2, "R6");
    step(0, 1, 0, 1, 4'hF, 6'd21, 32'd0, 0, "R6");
    for (int k = 1; k < 4; k++) step(0, 1, 1, 0, 4'h0, 6'd0, 32'hFFFF_FFFF, 0, "R6");
    idle(2, "R6");

    // R7: stalls with active-looking inputs between reads
    step(0, 1, 0, 1, 4'hF, 6'd8, 32'd0, 0, "R7");
    step(1, 1, 0, 0, 4'h0, 6'd8, 32'hDEAD_0001, 0, "R7");
    step(1, 1, 0, 0, 4'h0, 6'd9, 32'hDEAD_0002, 0, "R7");
    step(0, 1, 0, 1, 4'hF, 6'd9, 32'd0, 0, "R7");
    step(0, 1, 0, 1, 4'hF, 6'd10, 32'd0, 0, "R7");
    step(1, 0, 1, 0, 4'h0, 6'd10, 32'hDEAD_0003, 0, "R7");
    step(1, 1, 0, 1, 4'hF, 6'd11, 32'd0, 0, "R7");
    idle(2, "R7");
    for (int k = 8; k < 11; k++) step(0, 1, 0, 1, 4'hF, 6'(k), 32'd0, 0, "R7");
    idle(2, "R7");

    // R8: deselect with write intent, then continue-deselect cycles
    step(0, 0, 0, 0, 4'h0, 6'd33, 32'hBAD0_0033, 0, "R8");
    for (int k = 0; k < 3; k++) step(0, 1, 1, 0, 4'h0, 6'd33, 32'hBAD1_0033, 0, "R8");
    idle(2, "R8");
    step(0, 1, 0, 1, 4'hF, 6'd33, 32'd0, 0, "R8");
    step(0, 1, 0, 1, 4'hF, 6'd34, 32'd0, 0, "R8");
    idle(2, "R8");

    // R9: dummy read with output disabled, then enable while stalled
    step(0, 1, 0, 1, 4'hF, 6'd2, 32'd0, 1, "R9");
    step(0, 0, 0, 1, 4'hF, 6'd0, 32'd0, 1, "R9");
    step(0, 0, 0, 1, 4'hF, 6'd0, 32'd0, 1, "R9");
    step(1, 0, 0, 1, 4'hF, 6'd0, 32'd0, 0, "R9");
    step(1, 0, 0, 1, 4'hF, 6'd0, 32'd0, 1, "R9");
    idle(2, "R9");

    // R10: reset keeps the array and clears an in-flight read
    step(0, 1, 0, 0, 4'h0, 6'd60, 32'h600D_0060, 0, "R10");
    idle(2, "R10");
    step(0, 1, 0, 1, 4'hF, 6'd61, 32'd0, 0, "R10");
    do_reset();
    idle(3, "R10");
    step(0, 1, 0, 1, 4'hF, 6'd60, 32'd0, 0, "R10");
    step(0, 1, 0, 1, 4'hF, 6'd61, 32'd0, 0, "R10");
    idle(2, "R10");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule